// File: doc/BRIEF.md
# Clock Domain and Source Gating Controller

This block decides which clock domains and which clock sources of a chip are allowed to run. Software marks domains and sources as disabled through a small register bus. Each register group has three addresses: a direct-write one, a set-on-one one and a clear-on-one one. The controller does not stop a clock on the write alone. A domain is gated off only once every module on it reports idle or disabled. The CPU domain also needs the CPU to be in its wait-for-interrupt idle state. A source is gated off only when no running domain is still selected onto it.

The enables are modelled as flags (`dom_en`, `src_en`) that feed the real gating cells and oscillator controls elsewhere. The effective enables and a source-valid status can be read back, so software can tell a disable that is still pending from one that has completed. A wake-up event re-enables every domain at once.

Domain numbering:
- 0: CPU clock
- 1: system bus clock
- 2: peripheral bus clock
- 3 and 8: further bus clocks
- 4, 5, 10 and 11: asynchronous peripheral clocks
- 6: timer clock
- 7 and 9: not implemented

Source numbering:
- 0: main oscillator
- 1: first PLL
- 2: not implemented
- 3: external clock 1
- 4: low-frequency internal oscillator
- 5: high-frequency internal oscillator
- 6: second PLL
- 7: external clock 2

Top module: `ckg_ctrl`

## Requirements
- R1: After reset, all implemented domains run (`dom_en` = 0xD7F), both disable registers read back with only unimplemented bits cleared (domain 0x000, source 0xCA), and only sources 0, 4 and 5 run (`src_en` = 0x31, valid status 0x31).
- R2: Register addresses are as follows.
  - 0x0: domain disable, direct write.
  - 0x1: domain set. Each 1 written disables that domain; 0 bits have no effect.
  - 0x2: domain clear. Each 1 written re-enables that domain; 0 bits have no effect.
  - 0x4, 0x5, 0x6: the same three forms for sources.
  - Reads of 0x0 to 0x2 return the domain disable register, and reads of 0x4 to 0x6 return the source disable register.
- R3: A domain whose disable bit is set turns its enable off at the clock edge after the set write, provided its idle input is high. While its idle input is low, it keeps running.
- R4: Domain 0 (CPU) stops only when its disable bit is set and both `cpu_wfi` and `dom_idle[0]` are high.
- R5: Clearing a domain's disable bit turns its enable back on at the next edge, whatever its idle input.
- R6: A disabled source keeps running while any running domain selects it through `dom_src_sel` (3 bits per domain, domain d at bits [3d+2:3d]). It stops one edge after the last such domain stops.
- R7: The source-valid status (read at 0x8) shows a source one cycle after its enable rises, and drops it in the same cycle its enable falls.
- R8: A one-cycle `wake` pulse clears the domain disable register and turns on every implemented domain at the next edge, overriding a same-cycle write.
- R9: Domain bits 7 and 9 and source bit 2 always read 0, ignore writes, and keep their enables at 0.
- R10: Address 0x9 reads the effective domain enables and 0xA the effective source enables, so a pending disable shows as a set disable bit with the enable still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data for `bus_addr` (combinational) |
| dom_idle | input | 12 | Per-domain: all modules on the domain idle or disabled |
| dom_src_sel | input | 36 | Per-domain source number, 3 bits each |
| cpu_wfi | input | 1 | CPU is in wait-for-interrupt idle |
| wake | input | 1 | Wake-up event |
| dom_en | output | 12 | Effective domain clock enables |
| src_en | output | 8 | Effective source enables |

## Verification
A table of idle masks, CPU-idle levels and disable masks is applied in turn. Each entry is followed by a full clear. The entries separate four cases: gating an idle domain, holding a busy one, the extra CPU-idle condition on domain 0, and mixed masks where only the idle and disabled bits may drop. A directed sequence then keeps a PLL running on a domain that is still selected onto it. That domain is then disabled, which shows the one-edge lag of the source behind the domain and the valid flag falling together with the source. Further directed steps cover a wake pulse after all domains are off, writes to unimplemented bits, zero-bit writes, and a readback where a disable is pending but not yet taken.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DOM_OFF  = 4'h0;
  localparam logic [ADDR_W-1:0] A_DOM_SET  = 4'h1;
  localparam logic [ADDR_W-1:0] A_DOM_CLR  = 4'h2;
  localparam logic [ADDR_W-1:0] A_SRC_OFF  = 4'h4;
  localparam logic [ADDR_W-1:0] A_SRC_SET  = 4'h5;
  localparam logic [ADDR_W-1:0] A_SRC_CLR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_SRC_VLD  = 4'h8;
  localparam logic [ADDR_W-1:0] A_DOM_RUN  = 4'h9;
  localparam logic [ADDR_W-1:0] A_SRC_RUN  = 4'hA;
endpackage

// File: rtl/ckg_rst_sync.sv
module ckg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ckg_regs.sv
module ckg_regs
  import ckg_pkg::*;
#(
  parameter int NUM_DOM = 12,
  parameter int NUM_SRC = 8,
  parameter int DW      = 12,
  parameter logic [NUM_DOM-1:0] DOM_IMPL = 12'hD7F,
  parameter logic [NUM_SRC-1:0] SRC_IMPL = 8'hFB,
  parameter logic [NUM_SRC-1:0] SRC_BOOT = 8'h31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic               wake,
  input  logic [NUM_DOM-1:0] dom_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_valid,
  output logic [NUM_DOM-1:0] dom_off,
  output logic [NUM_SRC-1:0] src_off,
  output logic [DW-1:0]      rdata
);
  localparam logic [NUM_SRC-1:0] SRC_OFF_RST = SRC_IMPL & ~SRC_BOOT;

  logic [NUM_DOM-1:0] dom_off_q, dom_off_d;
  logic [NUM_SRC-1:0] src_off_q, src_off_d;
  logic [NUM_DOM-1:0] wd_dom;
  logic [NUM_SRC-1:0] wd_src;
  logic               upd_en;

  assign wd_dom = wdata[NUM_DOM-1:0];
  assign wd_src = wdata[NUM_SRC-1:0];
  assign upd_en = we | wake;

  always_comb begin
    dom_off_d = dom_off_q;
    src_off_d = src_off_q;
    if (we) begin
      case (addr)
        A_DOM_OFF: dom_off_d = wd_dom;
        A_DOM_SET: dom_off_d = dom_off_q | wd_dom;
        A_DOM_CLR: dom_off_d = dom_off_q & ~wd_dom;
        A_SRC_OFF: src_off_d = wd_src;
        A_SRC_SET: src_off_d = src_off_q | wd_src;
        A_SRC_CLR: src_off_d = src_off_q & ~wd_src;
        default: ;
      endcase
    end
    dom_off_d = dom_off_d & DOM_IMPL;
    src_off_d = src_off_d & SRC_IMPL;
    if (wake) dom_off_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_off_q <= '0;
      src_off_q <= SRC_OFF_RST;
    end else if (upd_en) begin
      dom_off_q <= dom_off_d;
      src_off_q <= src_off_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DOM_OFF, A_DOM_SET, A_DOM_CLR: rdata = DW'(dom_off_q);
      A_SRC_OFF, A_SRC_SET, A_SRC_CLR: rdata = DW'(src_off_q);
      A_SRC_VLD: rdata = DW'(src_valid);
      A_DOM_RUN: rdata = DW'(dom_en);
      A_SRC_RUN: rdata = DW'(src_en);
      default:   rdata = '0;
    endcase
  end

  assign dom_off = dom_off_q;
  assign src_off = src_off_q;

  AST_DOM_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DOM_SET && !wake) |=>
      ((dom_off_q & $past(wd_dom) & DOM_IMPL) == ($past(wd_dom) & DOM_IMPL))); // R2
  AST_DOM_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DOM_CLR) |=> ((dom_off_q & $past(wd_dom)) == '0)); // R2
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (dom_off_q == '0)); // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((dom_off_q & ~DOM_IMPL) == '0) && ((src_off_q & ~SRC_IMPL) == '0)); // R9
endmodule

// File: rtl/ckg_dom_gate.sv
module ckg_dom_gate #(
  parameter int NUM_DOM = 12,
  parameter logic [NUM_DOM-1:0] DOM_IMPL = 12'hD7F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DOM-1:0] dom_off,
  input  logic [NUM_DOM-1:0] dom_idle,
  input  logic               cpu_wfi,
  input  logic               wake,
  output logic [NUM_DOM-1:0] dom_en
);
  logic [NUM_DOM-1:0] idle_ok;
  logic [NUM_DOM-1:0] en_q, en_d;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == 0) begin : g_cpu
      assign idle_ok[d] = dom_idle[d] & cpu_wfi;
    end else begin : g_other
      assign idle_ok[d] = dom_idle[d];
    end

    assign en_d[d] = DOM_IMPL[d] & (wake | ~dom_off[d] | (en_q[d] & ~idle_ok[d]));

    AST_FALL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[d]) |-> $past(idle_ok[d] && dom_off[d])); // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[d] && !idle_ok[d]) |=> en_q[d]); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= DOM_IMPL;
    else        en_q <= en_d;
  end

  assign dom_en = en_q;

  AST_CPU_NEEDS_WFI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q[0]) |-> $past(cpu_wfi)); // R4
  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (en_q == DOM_IMPL)); // R8
endmodule

// File: rtl/ckg_src_gate.sv
module ckg_src_gate #(
  parameter int NUM_DOM = 12,
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 3,
  parameter logic [NUM_SRC-1:0] SRC_IMPL = 8'hFB,
  parameter logic [NUM_SRC-1:0] SRC_BOOT = 8'h31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DOM-1:0]       dom_en,
  input  logic [NUM_DOM*SEL_W-1:0] dom_src_sel,
  input  logic [NUM_SRC-1:0]       src_off,
  output logic [NUM_SRC-1:0]       src_en,
  output logic [NUM_SRC-1:0]       src_valid
);
  logic [NUM_SRC-1:0] in_use;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] vld_q;

  always_comb begin
    in_use = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (dom_en[d] && (dom_src_sel[d*SEL_W +: SEL_W] == SEL_W'(s)))
          in_use[s] = 1'b1;
      end
    end
  end

  assign en_d = SRC_IMPL & (~src_off | (en_q & in_use));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= SRC_BOOT & SRC_IMPL;
      vld_q <= SRC_BOOT & SRC_IMPL;
    end else begin
      en_q  <= en_d;
      vld_q <= en_q;
    end
  end

  assign src_en    = en_q;
  assign src_valid = vld_q & en_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    AST_SRC_HELD_BY_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[s] && in_use[s]) |=> en_q[s]); // R6
    AST_VALID_LAGS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[s]) |-> !src_valid[s]); // R7
    AST_VALID_DROPS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[s] |-> !src_valid[s]); // R7
  end
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int NUM_DOM = 12,
  parameter int NUM_SRC = 8,
  parameter logic [NUM_DOM-1:0] DOM_IMPL = 12'hD7F,
  parameter logic [NUM_SRC-1:0] SRC_IMPL = 8'hFB,
  parameter logic [NUM_SRC-1:0] SRC_BOOT = 8'h31,
  localparam int SEL_W = $clog2(NUM_SRC),
  localparam int DW    = (NUM_DOM > NUM_SRC) ? NUM_DOM : NUM_SRC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [NUM_DOM-1:0]       dom_idle,
  input  logic [NUM_DOM*SEL_W-1:0] dom_src_sel,
  input  logic                     cpu_wfi,
  input  logic                     wake,
  output logic [NUM_DOM-1:0]       dom_en,
  output logic [NUM_SRC-1:0]       src_en
);
  logic               rst_n_s;
  logic [NUM_DOM-1:0] dom_off;
  logic [NUM_SRC-1:0] src_off;
  logic [NUM_SRC-1:0] src_valid;

  ckg_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ckg_regs #(
    .NUM_DOM(NUM_DOM), .NUM_SRC(NUM_SRC), .DW(DW),
    .DOM_IMPL(DOM_IMPL), .SRC_IMPL(SRC_IMPL), .SRC_BOOT(SRC_BOOT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .wake(wake), .dom_en(dom_en), .src_en(src_en),
    .src_valid(src_valid), .dom_off(dom_off), .src_off(src_off),
    .rdata(bus_rdata)
  );

  ckg_dom_gate #(.NUM_DOM(NUM_DOM), .DOM_IMPL(DOM_IMPL)) u_dom (
    .clk(clk), .rst_n(rst_n_s), .dom_off(dom_off), .dom_idle(dom_idle),
    .cpu_wfi(cpu_wfi), .wake(wake), .dom_en(dom_en)
  );

  ckg_src_gate #(
    .NUM_DOM(NUM_DOM), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
    .SRC_IMPL(SRC_IMPL), .SRC_BOOT(SRC_BOOT)
  ) u_src (
    .clk(clk), .rst_n(rst_n_s), .dom_en(dom_en), .dom_src_sel(dom_src_sel),
    .src_off(src_off), .src_en(src_en), .src_valid(src_valid)
  );

  AST_SRC_LAGS_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(src_en[1]) |-> $past(src_off[1])); // R6
endmodule

// File: tb/sim_ckg_ctrl.sv
module sim_ckg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [11:0] bus_wdata;
  logic [11:0] bus_rdata;
  logic [11:0] dom_idle;
  logic [35:0] dom_src_sel;
  logic        cpu_wfi;
  logic        wake;
  logic [11:0] dom_en;
  logic [7:0]  src_en;

  int checks = 0;
  int failures = 0;

  localparam logic [11:0] IMPL = 12'hD7F;

  // {idle, wfi(4 bits), set mask, expected dom_en}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {12'hFFF, 4'h1, 12'h002, 12'hD7D},
    {12'h000, 4'h1, 12'h002, 12'hD7F},
    {12'hFFF, 4'h0, 12'h001, 12'hD7F},
    {12'hFFF, 4'h1, 12'h001, 12'hD7E},
    {12'h0F0, 4'h1, 12'h0FF, 12'hD0F},
    {12'hFFF, 4'h1, 12'hFFF, 12'h000},
    {12'hFFF, 4'h1, 12'h280, 12'hD7F},
    {12'hC00, 4'h0, 12'hD01, 12'h17F}
  };

  always #4 clk = ~clk;

  ckg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dom_idle(dom_idle),
    .dom_src_sel(dom_src_sel), .cpu_wfi(cpu_wfi), .wake(wake),
    .dom_en(dom_en), .src_en(src_en)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [11:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #800000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    dom_idle = '0; dom_src_sel = '0; cpu_wfi = 1'b0; wake = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 dom_en", dom_en, IMPL);
    chk("R1 src_en", 12'(src_en), 12'h031);
    rd(4'h0, r); chk("R1 dom_off", r, 12'h000);
    rd(4'h4, r); chk("R1 src_off", r, 12'h0CA);
    rd(4'h8, r); chk("R1 src_valid", r, 12'h031);

    // table walk: R3 R4 R5 R2
    for (int i = 0; i < NV; i++) begin
      dom_idle = VEC[i][39:28];
      cpu_wfi  = VEC[i][24];
      wr(4'h1, VEC[i][23:12]);
      tick();
      chk($sformatf("R3/R4 vec%0d dom_en", i), dom_en, VEC[i][11:0]);
      rd(4'h1, r);
      chk($sformatf("R2 vec%0d readback", i), r, VEC[i][23:12] & IMPL);
      wr(4'h2, 12'hFFF);
      tick();
      chk($sformatf("R5 vec%0d re-enable", i), dom_en, IMPL);
    end

    // R2 zero write and direct write
    dom_idle = '0; cpu_wfi = 1'b0;
    wr(4'h1, 12'h000);
    rd(4'h0, r); chk("R2 zero-bits no effect", r, 12'h000);
    wr(4'h0, 12'h006);
    rd(4'h0, r); chk("R2 direct write", r, 12'h006);
    wr(4'h2, 12'h004);
    rd(4'h0, r); chk("R2 clear one bit", r, 12'h002);
    wr(4'h0, 12'h000);

    // R10 pending vs completed disable
    wr(4'h1, 12'h004);
    tick();
    rd(4'h9, r); chk("R10 pending run", r, IMPL);
    rd(4'h0, r); chk("R10 pending off", r, 12'h004);
    dom_idle = 12'hFFF;
    tick();
    rd(4'h9, r); chk("R10 completed run", r, 12'hD7B);
    wr(4'h2, 12'h004);
    tick();

    // R6 / R7 source held by its user
    dom_src_sel[11:9] = 3'd1;
    wr(4'h6, 12'h002);
    chk("R7 src1 not yet", 12'(src_en), 12'h031);
    tick();
    chk("R7 src1 on", 12'(src_en), 12'h033);
    rd(4'h8, r); chk("R7 valid lags", r, 12'h031);
    tick();
    rd(4'h8, r); chk("R7 valid set", r, 12'h033);
    wr(4'h5, 12'h002);
    tick(); tick();
    chk("R6 held while used", 12'(src_en), 12'h033);
    rd(4'hA, r); chk("R10 src run", r, 12'h033);
    wr(4'h1, 12'h008);
    tick();
    chk("R6 domain off", dom_en, 12'hD77);
    chk("R6 src lags domain", 12'(src_en), 12'h033);
    tick();
    chk("R6 src off", 12'(src_en), 12'h031);
    rd(4'h8, r); chk("R7 valid drops", r, 12'h031);
    wr(4'h2, 12'h008);
    tick();

    // R9 unimplemented bits
    wr(4'h5, 12'h004);
    rd(4'h4, r); chk("R9 src bit2 ro", r, 12'h0CA);
    wr(4'h6, 12'h004);
    tick();
    chk("R9 src2 stays off", 12'(src_en), 12'h031);
    wr(4'h0, 12'hFFF);
    rd(4'h0, r); chk("R9 dom mask", r, IMPL);
    wr(4'h2, 12'hFFF);
    tick();

    // R8 wake
    dom_idle = 12'hFFF; cpu_wfi = 1'b1;
    wr(4'h1, 12'hFFF);
    tick();
    chk("R8 all off", dom_en, 12'h000);
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8 wake restores", dom_en, IMPL);
    rd(4'h0, r); chk("R8 wake clears off", r, 12'h000);
    tick();
    chk("R8 stays on", dom_en, IMPL);

    summary();
    $finish;
  end
endmodule